// File: doc/BRIEF.md
# Configurable Non-Cacheable Region Decoder

This block sits beside a processor's cache controller and answers one question for every bus address: may this access be cached? It keeps a small bank of byte-wide configuration registers, written one byte per transaction through an 8-bit register index. The lookup port takes a 32-bit physical address and returns a single non-cacheable flag. The flag is computed combinationally from the current register contents.

The bank has four programmable regions. Each region has a base address and a 4-bit size code. The size code selects a power-of-two window from 4 KB to 32 MB, selects the whole 4 GB space, or disables the region. A control register carries two enable bits for fixed legacy windows. The flag is the OR of every enabled match. All registers can be read back through the same index.

Top module: `nc_region_decoder`

## Requirements
- R1: After reset every register reads 0x00 and the flag is 0 for every address.
- R2: Region r (r = 0..3) occupies three consecutive indexes starting at 0xC4 + 3r. The first byte holds base bits 31..24. The second byte holds base bits 23..16. The third byte holds base bits 15..12 in bits 7..4 and the size code in bits 3..0. A written byte reads back unchanged from its index.
- R3: A size code s from 1 to 14 covers 4 KB << (s-1) bytes starting at the base. Size code 0 disables the region.
- R4: Size code 15 makes the region cover every 32-bit address, whatever its base bytes hold.
- R5: Base bits below the region size are ignored in the comparison, so a misaligned base selects the aligned window that contains it.
- R6: Control register index 0xC0, bit 0: when set, addresses whose bits 19..16 are all zero (the first 64 KB of each 1 MB block) are non-cacheable.
- R7: Control register bit 1: when set, addresses 0x000A0000 through 0x000FFFFF are non-cacheable.
- R8: The flag is the OR of all enabled region matches and both enabled fixed windows.
- R9: A write to any index other than 0xC0 and 0xC4..0xCF changes nothing, and a read of such an index returns 0xFF. Control register bits 7..2 ignore writes and read as 0.
- R10: A write captured at a clock edge changes the flag and the readback from that edge on. The flag does not change before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_wr_i | input | 1 | Write strobe for one configuration byte |
| cfg_idx_i | input | 8 | Register index for write and readback |
| cfg_wdata_i | input | 8 | Byte to write |
| cfg_rdata_o | output | 8 | Readback of the indexed register, combinational |
| lkp_addr_i | input | 32 | Physical address to classify |
| lkp_nocache_o | output | 1 | 1 when the address must not be cached |

## Verification
The flag and the readback are combinational from the registers. A written byte therefore shows up after exactly one rising edge, and an address change shows up with no edge at all. The bench drives writes on the falling edge and holds the strobe across one rising edge. It then checks the flag and readback just after the next falling edge, half a period after the capture. For R10 it also samples the flag while the strobe is still high but before the capturing edge, to confirm the old value still holds there. Address-only checks change the address and sample after a short settling delay, with no clock edge in between.

// File: rtl/nc_region_pkg.sv
package nc_region_pkg;
    localparam int NUM_REGIONS      = 4;
    localparam int BYTES_PER_REGION = 3;
    localparam int IDX_W            = 8;
    localparam int DATA_W           = 8;
    localparam int ADDR_W           = 32;
    localparam int PAGE_SHIFT       = 12;
    localparam int SIZE_W           = 4;
    localparam int CTRL_BITS        = 2;

    localparam logic [IDX_W-1:0]  CTRL_IDX      = 8'hC0;
    localparam logic [IDX_W-1:0]  REGION_IDX0   = 8'hC4;
    localparam logic [IDX_W-1:0]  REGION_IDX_END =
        IDX_W'(int'(REGION_IDX0) + NUM_REGIONS * BYTES_PER_REGION - 1);
    localparam logic [DATA_W-1:0] UNMAPPED_READ = 8'hFF;
    localparam logic [SIZE_W-1:0] SIZE_OFF      = 4'd0;
    localparam logic [SIZE_W-1:0] SIZE_FULL     = 4'd15;

    typedef struct packed {
        logic [7:0] base_hi;      // address bits 31..24
        logic [7:0] base_mid;     // address bits 23..16
        logic [7:0] base_lo_size; // [7:4] address bits 15..12, [3:0] size code
    } region_cfg_t;

    typedef struct packed {
        logic [CTRL_BITS-1:0]               ctrl;
        region_cfg_t [NUM_REGIONS-1:0]      region;
    } cfg_state_t;
endpackage

// File: rtl/nc_cfg_regs.sv
module nc_cfg_regs
    import nc_region_pkg::*;
(
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         wr_i,
    input  logic [IDX_W-1:0]             idx_i,
    input  logic [DATA_W-1:0]            wdata_i,
    output logic [DATA_W-1:0]            rdata_o,
    output logic [CTRL_BITS-1:0]         ctrl_o,
    output region_cfg_t [NUM_REGIONS-1:0] regions_o
);
    localparam int CFG_BITS = $bits(region_cfg_t);

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            if (idx_i == CTRL_IDX) begin
                st_d.ctrl = wdata_i[CTRL_BITS-1:0];
            end
            for (int r = 0; r < NUM_REGIONS; r++) begin
                for (int b = 0; b < BYTES_PER_REGION; b++) begin
                    if (idx_i == IDX_W'(int'(REGION_IDX0) + r * BYTES_PER_REGION + b)) begin
                        st_d.region[r][CFG_BITS-1-DATA_W*b -: DATA_W] = wdata_i;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = UNMAPPED_READ;
        if (idx_i == CTRL_IDX) begin
            rdata_o = DATA_W'(st_q.ctrl);
        end
        for (int r = 0; r < NUM_REGIONS; r++) begin
            for (int b = 0; b < BYTES_PER_REGION; b++) begin
                if (idx_i == IDX_W'(int'(REGION_IDX0) + r * BYTES_PER_REGION + b)) begin
                    rdata_o = st_q.region[r][CFG_BITS-1-DATA_W*b -: DATA_W];
                end
            end
        end
    end

    assign ctrl_o    = st_q.ctrl;
    assign regions_o = st_q.region;
endmodule

// File: rtl/nc_region_match.sv
module nc_region_match
    import nc_region_pkg::*;
(
    input  region_cfg_t       cfg_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);
    logic [SIZE_W-1:0] size_code;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] keep_mask;

    assign size_code = cfg_i.base_lo_size[SIZE_W-1:0];
    assign base      = {cfg_i.base_hi, cfg_i.base_mid, cfg_i.base_lo_size[7:4],
                        {PAGE_SHIFT{1'b0}}};

    always_comb begin
        keep_mask = '1;
        hit_o     = 1'b0;
        if (size_code == SIZE_FULL) begin
            hit_o = 1'b1;
        end else if (size_code != SIZE_OFF) begin
            keep_mask = {ADDR_W{1'b1}} << (PAGE_SHIFT - 1 + int'(size_code));
            hit_o     = ((addr_i ^ base) & keep_mask) == '0;
        end
    end
endmodule

// File: rtl/nc_legacy_match.sv
module nc_legacy_match
    import nc_region_pkg::*;
#(
    parameter int                  MB_SHIFT    = 20,
    parameter int                  BLOCK_SHIFT = 16,
    parameter logic [MB_SHIFT-1:0] HOLE_START  = 20'hA0000
) (
    input  logic [CTRL_BITS-1:0] ctrl_i,
    input  logic [ADDR_W-1:0]    addr_i,
    output logic                 hit_o
);
    logic low_block_hit;
    logic hole_hit;

    assign low_block_hit = ctrl_i[0] && (addr_i[MB_SHIFT-1:BLOCK_SHIFT] == '0);
    assign hole_hit      = ctrl_i[1] && (addr_i[ADDR_W-1:MB_SHIFT] == '0)
                           && (addr_i[MB_SHIFT-1:0] >= HOLE_START);
    assign hit_o         = low_block_hit || hole_hit;
endmodule

// File: rtl/nc_region_decoder.sv
module nc_region_decoder
    import nc_region_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_wr_i,
    input  logic [7:0]        cfg_idx_i,
    input  logic [7:0]        cfg_wdata_i,
    output logic [7:0]        cfg_rdata_o,
    input  logic [31:0]       lkp_addr_i,
    output logic              lkp_nocache_o
);
    logic [CTRL_BITS-1:0]          ctrl_bits;
    region_cfg_t [NUM_REGIONS-1:0] regions;
    logic [NUM_REGIONS-1:0]        region_hits;
    logic                          legacy_hit;

    nc_cfg_regs u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (cfg_wr_i),
        .idx_i     (cfg_idx_i),
        .wdata_i   (cfg_wdata_i),
        .rdata_o   (cfg_rdata_o),
        .ctrl_o    (ctrl_bits),
        .regions_o (regions)
    );

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
        nc_region_match u_match (
            .cfg_i  (regions[r]),
            .addr_i (lkp_addr_i),
            .hit_o  (region_hits[r])
        );
    end

    nc_legacy_match u_legacy (
        .ctrl_i (ctrl_bits),
        .addr_i (lkp_addr_i),
        .hit_o  (legacy_hit)
    );

    assign lkp_nocache_o = (|region_hits) || legacy_hit;
endmodule

// File: rtl/nc_region_decoder_chk.sv
module nc_region_decoder_chk
    import nc_region_pkg::*;
(
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 cfg_wr_i,
    input logic [7:0]           cfg_idx_i,
    input logic [7:0]           cfg_wdata_i,
    input logic [7:0]           cfg_rdata_o,
    input logic [31:0]          lkp_addr_i,
    input logic                 lkp_nocache_o,
    input logic [CTRL_BITS-1:0] ctrl_bits
);
    logic idx_region;
    logic idx_mapped;
    assign idx_region = (cfg_idx_i >= REGION_IDX0) && (cfg_idx_i <= REGION_IDX_END);
    assign idx_mapped = idx_region || (cfg_idx_i == CTRL_IDX);

    AST_RESET_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> !lkp_nocache_o); // R1

    AST_BYTE_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_wr_i && idx_region) |=> ($stable(cfg_idx_i) |-> cfg_rdata_o == $past(cfg_wdata_i))); // R2

    AST_UNMAPPED_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !idx_mapped |-> cfg_rdata_o == UNMAPPED_READ); // R9

    AST_CTRL_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_idx_i == CTRL_IDX) |-> cfg_rdata_o[7:CTRL_BITS] == '0); // R9

    AST_LOW_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_bits[0] && lkp_addr_i[19:16] == 4'h0) |-> lkp_nocache_o); // R6

    AST_LEGACY_HOLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_bits[1] && lkp_addr_i >= 32'h000A_0000 && lkp_addr_i <= 32'h000F_FFFF)
        |-> lkp_nocache_o); // R7
endmodule

bind nc_region_decoder nc_region_decoder_chk u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cfg_wr_i      (cfg_wr_i),
    .cfg_idx_i     (cfg_idx_i),
    .cfg_wdata_i   (cfg_wdata_i),
    .cfg_rdata_o   (cfg_rdata_o),
    .lkp_addr_i    (lkp_addr_i),
    .lkp_nocache_o (lkp_nocache_o),
    .ctrl_bits     (ctrl_bits)
);

// File: tb/nc_region_decoder_tb.sv
`timescale 1ns/1ps
module nc_region_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        cfg_wr_i = 1'b0;
    logic [7:0]  cfg_idx_i = 8'h00;
    logic [7:0]  cfg_wdata_i = 8'h00;
    logic [7:0]  cfg_rdata_o;
    logic [31:0] lkp_addr_i = 32'h0;
    logic        lkp_nocache_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] mdl [4][3];
    logic [1:0] mctrl;

    always #2.5 clk = ~clk;

    nc_region_decoder u_dut (
        .clk_i(clk), .rst_ni(rst_ni), .cfg_wr_i(cfg_wr_i), .cfg_idx_i(cfg_idx_i),
        .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o),
        .lkp_addr_i(lkp_addr_i), .lkp_nocache_o(lkp_nocache_o)
    );

    function automatic logic ref_nc(logic [31:0] a);
        logic hit = 1'b0;
        if (mctrl[0] && a[19:16] == 4'h0) hit = 1'b1;
        if (mctrl[1] && a >= 32'h000A_0000 && a < 32'h0010_0000) hit = 1'b1;
        for (int r = 0; r < 4; r++) begin
            logic [3:0]  s = mdl[r][2][3:0];
            logic [63:0] sz, base, lo;
            base = {32'h0, mdl[r][0], mdl[r][1], mdl[r][2][7:4], 12'h000};
            if (s == 4'd15) hit = 1'b1;
            else if (s != 4'd0) begin
                sz = 64'd4096 << (s - 1);
                lo = base - (base % sz);
                if ({32'h0, a} >= lo && {32'h0, a} < lo + sz) hit = 1'b1;
            end
        end
        return hit;
    endfunction

    task automatic check(logic [31:0] act, logic [31:0] exp, string req, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr_byte(logic [7:0] idx, logic [7:0] data);
        @(negedge clk);
        cfg_wr_i = 1'b1; cfg_idx_i = idx; cfg_wdata_i = data;
        @(negedge clk);
        cfg_wr_i = 1'b0;
        if (idx == 8'hC0) mctrl = data[1:0];
        else if (idx >= 8'hC4 && idx <= 8'hCF) mdl[(idx - 8'hC4) / 3][(idx - 8'hC4) % 3] = data;
    endtask

    task automatic rd_check(logic [7:0] idx, logic [7:0] exp, string req);
        cfg_idx_i = idx; #0.5;
        check(32'(cfg_rdata_o), 32'(exp), req, $sformatf("readback idx %h", idx));
    endtask

    task automatic look(logic [31:0] a, logic exp, string req);
        lkp_addr_i = a; #0.5;
        check(32'(lkp_nocache_o), 32'(exp), req, $sformatf("flag at %h", a));
    endtask

    task automatic prog_region(int r, logic [7:0] b0, logic [7:0] b1, logic [7:0] b2);
        wr_byte(8'(8'hC4 + 3 * r), b0);
        wr_byte(8'(8'hC5 + 3 * r), b1);
        wr_byte(8'(8'hC6 + 3 * r), b2);
    endtask

    task automatic clear_all();
        for (int i = 0; i < 12; i++) wr_byte(8'(8'hC4 + i), 8'h00);
        wr_byte(8'hC0, 8'h00);
    endtask

    task automatic t_reset();
        look(32'h0000_0000, 1'b0, "R1");
        look(32'h000A_0000, 1'b0, "R1");
        look(32'hFFFF_FFFF, 1'b0, "R1");
        rd_check(8'hC0, 8'h00, "R1");
        rd_check(8'hC4, 8'h00, "R1");
        rd_check(8'hCF, 8'h00, "R1");
    endtask

    task automatic t_readback();
        for (int i = 0; i < 12; i++) wr_byte(8'(8'hC4 + i), 8'(8'h30 + 8'h11 * i) & 8'hF0);
        for (int i = 0; i < 12; i++) rd_check(8'(8'hC4 + i), 8'(8'h30 + 8'h11 * i) & 8'hF0, "R2");
        clear_all();
    endtask

    task automatic t_latency();
        wr_byte(8'hC4, 8'h10);
        wr_byte(8'hC5, 8'h00);
        lkp_addr_i = 32'h1000_0000;
        @(negedge clk);
        cfg_wr_i = 1'b1; cfg_idx_i = 8'hC6; cfg_wdata_i = 8'h01;
        #0.5;
        check(32'(lkp_nocache_o), 32'h0, "R10", "flag before capture edge");
        @(negedge clk);
        cfg_wr_i = 1'b0;
        mdl[0][2] = 8'h01;
        check(32'(lkp_nocache_o), 32'h1, "R10", "flag after capture edge");
        clear_all();
    endtask

    task automatic t_sizes();
        for (int s = 1; s <= 14; s++) begin
            logic [31:0] sz = 32'd4096 << (s - 1);
            wr_byte(8'hC7, 8'h40);
            wr_byte(8'hC8, 8'h00);
            wr_byte(8'hC9, 8'(s));
            look(32'h4000_0000 - 1, 1'b0, "R3");
            look(32'h4000_0000, 1'b1, "R3");
            look(32'h4000_0000 + sz - 1, 1'b1, "R3");
            look(32'h4000_0000 + sz, 1'b0, "R3");
        end
        wr_byte(8'hC9, 8'h00);
        look(32'h4000_0000, 1'b0, "R3 code0");
        clear_all();
    endtask

    task automatic t_full();
        prog_region(2, 8'h12, 8'h34, 8'h5F);
        look(32'h0000_0000, 1'b1, "R4");
        look(32'hFFFF_FFFF, 1'b1, "R4");
        look(32'h8765_4321, 1'b1, "R4");
        clear_all();
    endtask

    task automatic t_misalign();
        prog_region(3, 8'h20, 8'h13, 8'h45);
        look(32'h2013_0000, 1'b1, "R5");
        look(32'h2013_FFFF, 1'b1, "R5");
        look(32'h2012_FFFF, 1'b0, "R5");
        look(32'h2014_0000, 1'b0, "R5");
        clear_all();
    endtask

    task automatic t_legacy();
        wr_byte(8'hC0, 8'h01);
        look(32'h0000_FFFF, 1'b1, "R6");
        look(32'h0001_0000, 1'b0, "R6");
        look(32'h0340_FFFF, 1'b1, "R6");
        look(32'h0345_0000, 1'b0, "R6");
        wr_byte(8'hC0, 8'h02);
        look(32'h0009_FFFF, 1'b0, "R7");
        look(32'h000A_0000, 1'b1, "R7");
        look(32'h000F_FFFF, 1'b1, "R7");
        look(32'h0010_0000, 1'b0, "R7");
        look(32'h001A_0000, 1'b0, "R7");
        wr_byte(8'hC0, 8'hFF);
        rd_check(8'hC0, 8'h03, "R9 ctrl upper");
        clear_all();
    endtask

    task automatic t_or();
        prog_region(0, 8'h08, 8'h00, 8'h09);
        prog_region(1, 8'h09, 8'h00, 8'h01);
        wr_byte(8'hC0, 8'h02);
        look(32'h080F_FFFF, 1'b1, "R8");
        look(32'h0810_0000, 1'b0, "R8");
        look(32'h0900_0FFF, 1'b1, "R8");
        look(32'h000B_0000, 1'b1, "R8");
        look(32'h0A00_0000, 1'b0, "R8");
        clear_all();
    endtask

    task automatic t_unmapped();
        logic [7:0] idxs [6] = '{8'hC1, 8'hC2, 8'hC3, 8'hD0, 8'h00, 8'hFF};
        foreach (idxs[i]) wr_byte(idxs[i], 8'h0F);
        foreach (idxs[i]) rd_check(idxs[i], 8'hFF, "R9");
        for (int i = 0; i < 12; i++) rd_check(8'(8'hC4 + i), 8'h00, "R9 regions untouched");
        rd_check(8'hC0, 8'h00, "R9 ctrl untouched");
        look(32'h0000_0000, 1'b0, "R9");
        look(32'h5A5A_5000, 1'b0, "R9");
    endtask

    task automatic t_random();
        for (int n = 0; n < 40; n++) begin
            int          r  = $urandom_range(0, 3);
            logic [3:0]  s  = (n % 8 == 7) ? 4'd15 : 4'($urandom_range(0, 14));
            logic [31:0] bs = $urandom;
            logic [31:0] sz;
            prog_region(r, bs[31:24], bs[23:16], {bs[15:12], s});
            if (n % 5 == 0) wr_byte(8'hC0, 8'($urandom_range(0, 3)));
            sz = (s == 0 || s == 15) ? 32'h1000 : (32'd4096 << (s - 1));
            bs = {bs[31:12], 12'h0} & ~(sz - 1);
            look(bs, ref_nc(bs), "R3 random");
            look(bs - 1, ref_nc(bs - 1), "R5 random");
            look(bs + sz - 1, ref_nc(bs + sz - 1), "R3 random");
            look(bs + sz, ref_nc(bs + sz), "R8 random");
            begin
                logic [31:0] ra = $urandom;
                look(ra, ref_nc(ra), "R8 random");
            end
        end
    endtask

    initial begin
        for (int r = 0; r < 4; r++) for (int b = 0; b < 3; b++) mdl[r][b] = 8'h00;
        mctrl = 2'b00;
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_latency();
        t_sizes();
        t_full();
        t_misalign();
        t_legacy();
        t_or();
        t_unmapped();
        t_random();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule